// File: doc/BRIEF.md
# SPI Slave Front End with Hold and Strap Addressing

This block is the serial edge of a small register-based peripheral. It receives an SPI mode-0 style stream (data captured on rising SCK, output changed on falling SCK). A system clock at least eight times faster than SCK samples the stream. Chip select, serial clock, serial data and the active-low hold input each pass through a two-flop synchroniser, and SCK edges are found from the synchronised samples. Every byte shifted in is handed to a downstream controller as a one-cycle strobe. The controller answers through a load port whose byte is shifted out MSB first, with an output enable that stands for a tri-state pin.

The first byte of each frame carries the device address in its two low bits, and the opcode sits above them. When that address equals the value on two strap inputs, the frame is accepted. Otherwise the block stays silent until chip select rises. A hold input pauses a frame: it takes effect when hold is low while SCK is low. While paused, SCK and SI are ignored and the output is floated. Releasing hold while SCK is low resumes at the same bit. Each chip-select rise produces a one-cycle event that reports whether the frame ended on a whole-byte boundary.

Top module: `spi_hold_slave`

## Requirements
- R1: After reset `sdo_oe_o`, `rx_valid_o` and `cs_end_o` are all 0.
- R2: SI is captured on each SCK rising edge, MSB first. After every 8th rising edge of an accepted frame, `rx_valid_o` pulses for one cycle with the assembled byte on `rx_byte_o`.
- R3: The first byte after chip select falls is the instruction byte. Its strobe carries `rx_first_o` = 1, and every later byte carries 0. The device address is instruction bits [1:0].
- R4: If instruction bits [1:0] differ from `strap_i`, the frame produces no strobe, and `sdo_oe_o` stays 0 until chip select rises.
- R5: In an accepted frame, `sdo_oe_o` is 1 from the second byte on. A byte loaded with `tx_load_i` is presented MSB first and advances one bit on each SCK falling edge that follows a rising edge within the byte.
- R6: Chip select high turns `sdo_oe_o` off and ends the frame. The next chip-select fall restarts the bit count at 0, even after a partial byte.
- R7: Hold low while SCK is low pauses the frame. During the pause `sdo_oe_o` is 0, and SCK and SI are ignored. Releasing hold while SCK is low resumes shifting at the same bit in both directions.
- R8: A hold pulse that starts and ends while SCK is high has no effect on the transfer.
- R9: Each chip-select rise that ends a frame gives a one-cycle `cs_end_o` pulse. `cs_end_aligned_o` is 1 when the number of rising edges received was a multiple of 8, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock, idle low |
| sdi_i | input | 1 | Serial data in |
| csn_i | input | 1 | Active-low chip select |
| holdn_i | input | 1 | Active-low pause request |
| strap_i | input | ADDR_W | Device address straps |
| tx_load_i | input | 1 | Load `tx_byte_i` into the output shifter |
| tx_byte_i | input | 8 | Byte to transmit |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data pin |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_first_o | output | 1 | Marks the strobed byte as the instruction byte |
| rx_byte_o | output | 8 | Received byte |
| cs_end_o | output | 1 | One-cycle event on chip-select rise |
| cs_end_aligned_o | output | 1 | Frame ended on a byte boundary (valid with `cs_end_o`) |

## Verification
The bench sweeps all sixteen combinations of strap value and instruction address with three-byte frames. Each frame sends computed data bytes, and a bench-side controller loads each received byte XOR 0xA5. The sweep therefore separates an accepted frame, which must return the previous byte on SO with the enable on, from a rejected one, which must stay silent and strobe nothing. One frame pauses mid-byte with spurious SCK pulses during the hold, which shows that both shift directions freeze and resume at the same bit. Another frame pulses hold only while SCK is high, to show it has no effect. Partial frames followed by full ones separate the aligned and unaligned end events and show that the bit count restarts.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic             sck_prev;
        logic             csn_prev;
        logic             active;
        logic             held;
        logic             first;
        logic             matched;
        logic [CNT_W-1:0] cnt;
        byte_t            sh;
        logic             rx_valid;
        logic             rx_first;
        byte_t            rx_byte;
        logic             end_evt;
        logic             end_aligned;
    } frame_t;

    typedef struct packed {
        byte_t sh;
    } tx_t;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_hold_frame.sv
module spi_hold_frame
    import spi_hold_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic              csn_s,
    input  logic              holdn_s,
    input  logic [ADDR_W-1:0] strap_i,
    output logic              active_o,
    output logic              matched_o,
    output logic              held_o,
    output logic              fall_go_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              rx_valid_o,
    output logic              rx_first_o,
    output byte_t             rx_byte_o,
    output logic              end_evt_o,
    output logic              end_aligned_o
);
    frame_t frm_d, frm_q;
    logic   rise, fall;

    always_comb begin
        frm_d          = frm_q;
        frm_d.rx_valid = 1'b0;
        frm_d.rx_first = 1'b0;
        frm_d.end_evt  = 1'b0;
        frm_d.end_aligned = 1'b0;
        frm_d.sck_prev = sck_s;
        frm_d.csn_prev = csn_s;
        rise      = sck_s & ~frm_q.sck_prev;
        fall      = ~sck_s & frm_q.sck_prev;
        fall_go_o = 1'b0;

        if (csn_s) begin
            if (frm_q.active) begin
                frm_d.end_evt     = 1'b1;
                frm_d.end_aligned = (frm_q.cnt == '0);
            end
            frm_d.active  = 1'b0;
            frm_d.held    = 1'b0;
            frm_d.matched = 1'b0;
        end else if (frm_q.csn_prev) begin
            frm_d.active  = 1'b1;
            frm_d.first   = 1'b1;
            frm_d.matched = 1'b0;
            frm_d.held    = 1'b0;
            frm_d.cnt     = '0;
            frm_d.sh      = '0;
        end else if (frm_q.active) begin
            if (!sck_s) begin
                frm_d.held = ~holdn_s;
            end
            if (!frm_q.held) begin
                if (rise) begin
                    frm_d.sh  = {frm_q.sh[BYTE_W-2:0], sdi_s};
                    frm_d.cnt = frm_q.cnt + 1'b1;
                    if (frm_q.cnt == CNT_W'(BYTE_W-1)) begin
                        frm_d.rx_byte = frm_d.sh;
                        if (frm_q.first) begin
                            frm_d.first = 1'b0;
                            if (frm_d.sh[ADDR_W-1:0] == strap_i) begin
                                frm_d.matched  = 1'b1;
                                frm_d.rx_valid = 1'b1;
                                frm_d.rx_first = 1'b1;
                            end
                        end else if (frm_q.matched) begin
                            frm_d.rx_valid = 1'b1;
                        end
                    end
                end
                if (fall && frm_q.matched) begin
                    fall_go_o = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '0;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign active_o      = frm_q.active;
    assign matched_o     = frm_q.matched;
    assign held_o        = frm_q.held;
    assign cnt_o         = frm_q.cnt;
    assign rx_valid_o    = frm_q.rx_valid;
    assign rx_first_o    = frm_q.rx_first;
    assign rx_byte_o     = frm_q.rx_byte;
    assign end_evt_o     = frm_q.end_evt;
    assign end_aligned_o = frm_q.end_aligned;
endmodule

// File: rtl/spi_hold_tx.sv
module spi_hold_tx
    import spi_hold_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  byte_t            load_byte_i,
    input  logic             fall_go_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             sdo_o
);
    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (load_i) begin
            tx_d.sh = load_byte_i;
        end else if (fall_go_i && (cnt_i != '0)) begin
            tx_d.sh = {tx_q.sh[BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign sdo_o = tx_q.sh[BYTE_W-1];
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
    import spi_hold_pkg::*;
#(
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              csn_i,
    input  logic              holdn_i,
    input  logic [ADDR_W-1:0] strap_i,
    input  logic              tx_load_i,
    input  logic [7:0]        tx_byte_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              rx_valid_o,
    output logic              rx_first_o,
    output logic [7:0]        rx_byte_o,
    output logic              cs_end_o,
    output logic              cs_end_aligned_o
);
    localparam int unsigned NSYNC = 4;

    logic [NSYNC-1:0] sync_w;
    logic             csn_s, holdn_s, sck_s, sdi_s;
    logic             active_w, matched_w, held_w, fall_go_w;
    logic [CNT_W-1:0] cnt_w;

    spi_hold_sync #(
        .W       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1100)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({csn_i, holdn_i, sck_i, sdi_i}),
        .sync_o  (sync_w)
    );

    assign {csn_s, holdn_s, sck_s, sdi_s} = sync_w;

    spi_hold_frame #(
        .ADDR_W (ADDR_W)
    ) frame_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .sck_s         (sck_s),
        .sdi_s         (sdi_s),
        .csn_s         (csn_s),
        .holdn_s       (holdn_s),
        .strap_i       (strap_i),
        .active_o      (active_w),
        .matched_o     (matched_w),
        .held_o        (held_w),
        .fall_go_o     (fall_go_w),
        .cnt_o         (cnt_w),
        .rx_valid_o    (rx_valid_o),
        .rx_first_o    (rx_first_o),
        .rx_byte_o     (rx_byte_o),
        .end_evt_o     (cs_end_o),
        .end_aligned_o (cs_end_aligned_o)
    );

    spi_hold_tx tx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (tx_load_i),
        .load_byte_i (tx_byte_i),
        .fall_go_i   (fall_go_w),
        .cnt_i       (cnt_w),
        .sdo_o       (sdo_o)
    );

    assign sdo_oe_o = active_w & matched_w & ~held_w;
endmodule

// File: rtl/spi_hold_chk.sv
module spi_hold_chk
    import spi_hold_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csn_s,
    input logic              held,
    input logic [CNT_W-1:0]  cnt,
    input logic              sdo_oe,
    input logic              rx_valid,
    input logic              rx_first,
    input logic [7:0]        rx_byte,
    input logic [ADDR_W-1:0] strap,
    input logic              cs_end
);
    p_byte_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_first_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_first) |-> (rx_byte[ADDR_W-1:0] == strap));

    p_oe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !sdo_oe);

    p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !csn_s) |=> $stable(cnt));

    p_end_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_end |=> !cs_end);
endmodule

bind spi_hold_slave spi_hold_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn_s    (csn_s),
    .held     (held_w),
    .cnt      (cnt_w),
    .sdo_oe   (sdo_oe_o),
    .rx_valid (rx_valid_o),
    .rx_first (rx_first_o),
    .rx_byte  (rx_byte_o),
    .strap    (strap_i),
    .cs_end   (cs_end_o)
);

// File: tb/spi_hold_slave_tb_top.sv
`timescale 1ns/1ps
module spi_hold_slave_tb_top;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n, sck_i, sdi_i, csn_i, holdn_i, tx_load_i;
    logic [1:0] strap_i;
    logic [7:0] tx_byte_i, rx_byte_o;
    logic       sdo_o, sdo_oe_o, rx_valid_o, rx_first_o, cs_end_o, cs_end_aligned_o;

    int n_chk = 0;
    int n_bad = 0;
    int end_cnt = 0;
    bit end_al = 1'b0;
    bit done = 1'b0;
    logic [7:0] rx_b[$];
    bit         rx_f[$];

    always #2.5 clk = ~clk;

    spi_hold_slave dut_i (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .sdi_i(sdi_i), .csn_i(csn_i),
        .holdn_i(holdn_i), .strap_i(strap_i), .tx_load_i(tx_load_i),
        .tx_byte_i(tx_byte_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
        .rx_valid_o(rx_valid_o), .rx_first_o(rx_first_o), .rx_byte_o(rx_byte_o),
        .cs_end_o(cs_end_o), .cs_end_aligned_o(cs_end_aligned_o)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // bench-side controller: records strobes, answers each byte with byte ^ A5
    initial begin
        tx_load_i = 1'b0;
        tx_byte_i = 8'h00;
        forever begin
            @(negedge clk);
            tx_load_i = 1'b0;
            if (rx_valid_o) begin
                rx_b.push_back(rx_byte_o);
                rx_f.push_back(rx_first_o);
                tx_byte_i = rx_byte_o ^ 8'hA5;
                tx_load_i = 1'b1;
            end
            if (cs_end_o) begin
                end_cnt++;
                end_al = cs_end_aligned_o;
            end
        end
    end

    // R7: pause with spurious SCK pulses and SI toggles while held
    task automatic do_hold();
        holdn_i = 1'b0;
        cyc(HALF);
        chk(sdo_oe_o == 1'b0, "R7 enable off at hold entry", sdo_oe_o, 0);
        for (int p = 0; p < 3; p++) begin
            sdi_i = ~sdi_i;
            sck_i = 1'b1;
            cyc(HALF);
            sck_i = 1'b0;
            cyc(HALF);
        end
        chk(sdo_oe_o == 1'b0, "R7 enable off during hold", sdo_oe_o, 0);
        holdn_i = 1'b1;
        cyc(HALF);
    endtask

    task automatic send_frame(input logic [7:0] i0, input logic [7:0] i1, input logic [7:0] i2,
                              input int nbytes, input int extra, input bit match,
                              input int hold_bit, input int hold_mode);
        logic [7:0] by [3];
        logic [7:0] got;
        logic       so, oe;
        int         oe_bad, pos, ends0;
        by[0] = i0; by[1] = i1; by[2] = i2;
        rx_b.delete();
        rx_f.delete();
        ends0 = end_cnt;
        pos = 0;
        csn_i = 1'b0;
        cyc(HALF);
        for (int i = 0; i < nbytes; i++) begin
            got = 8'h00;
            oe_bad = 0;
            for (int k = 7; k >= 0; k--) begin
                sdi_i = by[i][k];
                cyc(HALF);
                so = sdo_o;
                oe = sdo_oe_o;
                sck_i = 1'b1;
                if (hold_mode == 2 && pos == hold_bit) begin
                    // R8: hold pulse confined to SCK high
                    cyc(2); holdn_i = 1'b0; cyc(3); holdn_i = 1'b1; cyc(HALF-5);
                end else begin
                    cyc(HALF);
                end
                sck_i = 1'b0;
                got = {got[6:0], so};
                if (oe !== (match && i > 0)) oe_bad++;
                if (hold_mode == 1 && pos == hold_bit) do_hold();
                pos++;
            end
            if (match) chk(oe_bad == 0, "R5 enable during byte", oe_bad, 0);
            else       chk(oe_bad == 0, "R4 enable stays off", oe_bad, 0);
            if (match && i > 0)
                chk(got == (by[i-1] ^ 8'hA5), "R5 serial output byte", got, by[i-1] ^ 8'hA5);
        end
        for (int e = 0; e < extra; e++) begin
            sdi_i = 1'b1;
            cyc(HALF);
            sck_i = 1'b1;
            cyc(HALF);
            sck_i = 1'b0;
        end
        cyc(HALF);
        csn_i = 1'b1;
        cyc(HALF);
        chk(sdo_oe_o == 1'b0, "R6 enable off after deselect", sdo_oe_o, 0);
        chk(end_cnt == ends0 + 1, "R9 end event count", end_cnt - ends0, 1);
        chk(end_al == (extra == 0), "R9 aligned flag", end_al, (extra == 0));
        if (match) begin
            chk(rx_b.size() == nbytes, "R2 strobe count", rx_b.size(), nbytes);
            for (int i = 0; i < nbytes && i < rx_b.size(); i++) begin
                chk(rx_b[i] == by[i], "R2 received byte", rx_b[i], by[i]);
                chk(rx_f[i] == (i == 0), "R3 first flag", rx_f[i], (i == 0));
            end
        end else begin
            chk(rx_b.size() == 0, "R4 no strobes on mismatch", rx_b.size(), 0);
        end
        cyc(HALF);
    endtask

    initial begin
        rst_n = 1'b0; sck_i = 1'b0; sdi_i = 1'b0; csn_i = 1'b1; holdn_i = 1'b1; strap_i = 2'd0;
        cyc(5);
        chk(sdo_oe_o == 1'b0, "R1 enable in reset", sdo_oe_o, 0);
        chk(rx_valid_o == 1'b0 && cs_end_o == 1'b0, "R1 strobes in reset", rx_valid_o, 0);
        rst_n = 1'b1;
        cyc(6);
        chk(sdo_oe_o == 1'b0 && cs_end_o == 1'b0, "R1 idle after reset", sdo_oe_o, 0);

        // sweep: every strap value against every instruction address
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 4; a++) begin
                logic [7:0] ins, d1;
                strap_i = 2'(s);
                ins = {6'(s*11 + a*5 + 3), 2'(a)};
                d1  = 8'(s*37 + a*19 + 1);
                send_frame(ins, d1, ~d1, 3, 0, (s == a), -1, 0);
            end
        end

        strap_i = 2'd2;
        send_frame(8'h32, 8'hC3, 8'h5E, 3, 0, 1'b1, 11, 1);   // R7 mid-byte pause
        send_frame(8'hB6, 8'h69, 8'h0F, 3, 0, 1'b1, 13, 2);   // R8 hold only while SCK high
        send_frame(8'h7E, 8'h81, 8'h00, 2, 5, 1'b1, -1, 0);   // R9 unaligned end, R6 partial
        send_frame(8'h4D, 8'h00, 8'h00, 1, 3, 1'b0, -1, 0);   // R4 mismatch, partial
        send_frame(8'hEA, 8'h17, 8'hF0, 3, 0, 1'b1, -1, 0);   // R6 count restarts at 0

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end
endmodule